// File: doc/BRIEF.md
# Hi/Lo Multiply-Divide Unit

This block is a sequential integer multiply and divide engine that owns a pair of result registers, `hi` and `lo`. A one-cycle `start` strobe launches one of four operations on two operands. The operations are signed multiply, unsigned multiply, signed divide and unsigned divide. The unit then works through one operand bit per clock for 32 cycles. On the last cycle it writes the whole 64-bit outcome into the register pair. A multiply leaves the product split across the pair. A divide leaves the quotient in `lo` and the remainder in `hi`.

The pair can also be loaded directly from a data input, one register at a time, and read back through a request/valid read port. While an operation is in flight the unit reports `busy`, holds off reads, and refuses both new starts and direct loads. No operation ever signals an error. A zero divisor produces a fixed, defined result.

Top module: `hilo_mdu`

## Requirements
- R1: With `op[1]`=0 the operation is a multiply: the low 32 bits of the product land in `lo` and the high 32 bits in `hi`. With `op[0]`=1 the operands are taken as unsigned.
- R2: With `op`=2'b00 both operands are two's-complement signed, and the 64-bit product carries the correct sign.
- R3: With `op`=2'b11 (unsigned divide) and a non-zero divisor, `lo` receives the quotient and `hi` the remainder.
- R4: With `op`=2'b10 (signed divide) and a non-zero divisor, the quotient is truncated toward zero and the remainder takes the sign of the dividend. The case 0x80000000 / 0xFFFFFFFF gives `lo`=0x80000000 and `hi`=0.
- R5: A zero divisor, signed or unsigned, sets `lo` to all ones and `hi` to the dividend as given, with no error indication.
- R6: `busy` rises on the clock edge that accepts `start` while idle. It stays high for exactly 32 cycles and falls on the edge that writes `hi` and `lo`.
- R7: A `start` while `busy` is high is ignored. The running operation neither restarts nor lengthens, and its result is unchanged.
- R8: While idle, `wr_hi` or `wr_lo` loads `wr_data` into that register at the next edge and leaves the other register unchanged.
- R9: `wr_hi`/`wr_lo` while busy are ignored. The finishing operation overwrites both `hi` and `lo`.
- R10: `rd_valid` equals `rd_req` while idle and stays low while busy. `rd_data` shows `hi` when `rd_sel`=1 and `lo` when `rd_sel`=0.
- R11: After synchronous reset `hi` and `lo` read 0 and `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch an operation (accepted only when idle) |
| op | input | 2 | Operation: bit 1 selects divide, bit 0 selects unsigned |
| src_a | input | 32 | Multiplicand or dividend |
| src_b | input | 32 | Multiplier or divisor |
| wr_hi | input | 1 | Load `hi` from `wr_data` when idle |
| wr_lo | input | 1 | Load `lo` from `wr_data` when idle |
| wr_data | input | 32 | Data for direct loads |
| rd_req | input | 1 | Read request |
| rd_sel | input | 1 | Read select: 1 = `hi`, 0 = `lo` |
| busy | output | 1 | Operation in flight |
| rd_valid | output | 1 | Read request granted this cycle |
| rd_data | output | 32 | Selected register contents |

## Verification
Multiplies are run with small unsigned values, with all-ones operands that fill the carry into the top half, and with mixed-sign and most-negative signed pairs. Together these separate a missing sign correction from a lost carry. Divides cover every sign combination of signed operands, which exposes floor-versus-truncate and remainder-sign mistakes, as well as the overflow quotient of the most negative value by minus one. They also cover a dividend smaller than the divisor and zero divisors in both modes. Directed sequences then check the 32-cycle busy window, and they check that starts, direct loads and reads issued mid-operation change nothing.

// File: rtl/hilo_pkg.sv
package hilo_pkg;

    localparam int unsigned XLEN = 32;

    typedef enum logic [1:0] {
        OP_MUL_S = 2'b00,
        OP_MUL_U = 2'b01,
        OP_DIV_S = 2'b10,
        OP_DIV_U = 2'b11
    } mdu_op_e;

    // Per-operation context captured when a start is accepted
    typedef struct packed {
        logic is_div;   // divide datapath selected
        logic neg_lo;   // negate low result (quotient / product)
        logic neg_hi;   // negate high result (remainder)
        logic dz;       // divisor was zero
    } mdu_job_t;

endpackage

// File: rtl/hilo_mul_step.sv
module hilo_mul_step #(
    parameter int W = 32
) (
    input  logic [2*W-1:0] acc,
    input  logic [W-1:0]   mcand,
    output logic [2*W-1:0] nxt
);
    logic [W:0] sum;

    always_comb begin
        sum = {1'b0, acc[2*W-1:W]} + (acc[0] ? {1'b0, mcand} : '0);
        nxt = {sum, acc[W-1:1]};
    end
endmodule

// File: rtl/hilo_div_step.sv
module hilo_div_step #(
    parameter int W = 32
) (
    input  logic [2*W-1:0] acc,
    input  logic [W-1:0]   dvsr,
    output logic [2*W-1:0] nxt
);
    logic [W:0] shifted;
    logic [W:0] diff;
    logic       fits;

    always_comb begin
        shifted = {acc[2*W-1:W], acc[W-1]};
        diff    = shifted - {1'b0, dvsr};
        fits    = ~diff[W];
        if (fits) nxt = {diff[W-1:0],    acc[W-2:0], 1'b1};
        else      nxt = {shifted[W-1:0], acc[W-2:0], 1'b0};
    end
endmodule

// File: rtl/hilo_mdu.sv
module hilo_mdu
    import hilo_pkg::*;
#(
    parameter int W = hilo_pkg::XLEN
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [1:0]   op,
    input  logic [W-1:0] src_a,
    input  logic [W-1:0] src_b,
    input  logic         wr_hi,
    input  logic         wr_lo,
    input  logic [W-1:0] wr_data,
    input  logic         rd_req,
    input  logic         rd_sel,
    output logic         busy,
    output logic         rd_valid,
    output logic [W-1:0] rd_data
);
    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic             busy_q;
    logic [CW-1:0]    cnt_q;
    logic [2*W-1:0]   acc_q;
    logic [W-1:0]     opnd_q;
    logic [W-1:0]     dvd_q;
    mdu_job_t         job_q;
    logic [W-1:0]     hi_q, lo_q;

    mdu_op_e          op_e;
    logic             accept, sgn, a_neg, b_neg, is_div;
    logic [W-1:0]     a_mag, b_mag;
    mdu_job_t         job_d;
    logic [2*W-1:0]   acc_init;
    logic [W-1:0]     opnd_init;

    logic [2*W-1:0]   mul_nxt, div_nxt, step_nxt, prod;
    logic [W-1:0]     res_hi, res_lo;

    // Operand preparation: magnitudes and sign bookkeeping
    always_comb begin
        op_e   = mdu_op_e'(op);
        accept = start & ~busy_q;
        is_div = (op_e == OP_DIV_S) || (op_e == OP_DIV_U);
        sgn    = (op_e == OP_MUL_S) || (op_e == OP_DIV_S);
        a_neg  = sgn & src_a[W-1];
        b_neg  = sgn & src_b[W-1];
        a_mag  = a_neg ? -src_a : src_a;
        b_mag  = b_neg ? -src_b : src_b;

        job_d.is_div = is_div;
        job_d.neg_lo = a_neg ^ b_neg;
        job_d.neg_hi = is_div ? a_neg : (a_neg ^ b_neg);
        job_d.dz     = is_div && (src_b == '0);

        if (is_div) begin
            acc_init  = {{W{1'b0}}, a_mag};
            opnd_init = b_mag;
        end else begin
            acc_init  = {{W{1'b0}}, b_mag};
            opnd_init = a_mag;
        end
    end

    hilo_mul_step #(.W(W)) u_mul (.acc(acc_q), .mcand(opnd_q), .nxt(mul_nxt));
    hilo_div_step #(.W(W)) u_div (.acc(acc_q), .dvsr(opnd_q),  .nxt(div_nxt));

    // Result shaping applied on the final iteration
    always_comb begin
        step_nxt = job_q.is_div ? div_nxt : mul_nxt;
        prod     = job_q.neg_lo ? -step_nxt : step_nxt;
        if (!job_q.is_div) begin
            res_hi = prod[2*W-1:W];
            res_lo = prod[W-1:0];
        end else if (job_q.dz) begin
            res_hi = dvd_q;
            res_lo = '1;
        end else begin
            res_hi = job_q.neg_hi ? -step_nxt[2*W-1:W] : step_nxt[2*W-1:W];
            res_lo = job_q.neg_lo ? -step_nxt[W-1:0]   : step_nxt[W-1:0];
        end
    end

    // Sequencer
    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            acc_q  <= '0;
            opnd_q <= '0;
            dvd_q  <= '0;
            job_q  <= '0;
        end else if (accept) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
            acc_q  <= acc_init;
            opnd_q <= opnd_init;
            dvd_q  <= src_a;
            job_q  <= job_d;
        end else if (busy_q) begin
            acc_q <= step_nxt;
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST) busy_q <= 1'b0;
        end
    end

    // Result register pair
    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q <= '0;
            lo_q <= '0;
        end else if (busy_q) begin
            if (cnt_q == LAST) begin
                hi_q <= res_hi;
                lo_q <= res_lo;
            end
        end else begin
            if (wr_hi) hi_q <= wr_data;
            if (wr_lo) lo_q <= wr_data;
        end
    end

    assign busy     = busy_q;
    assign rd_valid = rd_req & ~busy_q;
    assign rd_data  = rd_sel ? hi_q : lo_q;

    // Checks
    assert_accept_busy_R6: assert property (@(posedge clk) disable iff (rst)
        (start && !busy_q) |=> busy_q);

    assert_done_count_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_q) |-> ($past(cnt_q) == LAST));

    assert_start_ignored_R7: assert property (@(posedge clk) disable iff (rst)
        (busy_q && start && cnt_q != LAST) |=> busy_q);

    assert_regs_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (busy_q && $past(busy_q)) |-> ($stable(hi_q) && $stable(lo_q)));

    assert_zero_div_R5: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy_q) && $past(job_q.dz)) |-> (lo_q == '1 && hi_q == $past(dvd_q)));

endmodule

// File: tb/hilo_mdu_test.sv
module hilo_mdu_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [1:0]  op;
    logic [31:0] src_a, src_b, wr_data, rd_data;
    logic        wr_hi, wr_lo, rd_req, rd_sel, busy, rd_valid;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    hilo_mdu uut (
        .clk(clk), .rst(rst), .start(start), .op(op),
        .src_a(src_a), .src_b(src_b),
        .wr_hi(wr_hi), .wr_lo(wr_lo), .wr_data(wr_data),
        .rd_req(rd_req), .rd_sel(rd_sel),
        .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    // {op, a, b}
    localparam int NV = 14;
    localparam logic [65:0] VEC [NV] = '{
        {2'b01, 32'd3,          32'd5},
        {2'b01, 32'hFFFFFFFF,   32'hFFFFFFFF},
        {2'b01, 32'h12345678,   32'h9ABCDEF0},
        {2'b00, 32'hFFFFFFFF,   32'hFFFFFFFF},
        {2'b00, 32'h7FFFFFFF,   32'hFFFFFFFE},
        {2'b00, 32'h80000000,   32'h80000000},
        {2'b11, 32'd100,        32'd7},
        {2'b11, 32'hFFFFFFFF,   32'd1},
        {2'b11, 32'd5,          32'd9},
        {2'b10, 32'hFFFFFFF9,   32'd2},
        {2'b10, 32'd7,          32'hFFFFFFFE},
        {2'b10, 32'h80000000,   32'hFFFFFFFF},
        {2'b10, 32'hFFFFFFF9,   32'd0},
        {2'b11, 32'd1234,       32'd0}
    };

    function automatic logic [63:0] model(input logic [1:0] o, input logic [31:0] a, input logic [31:0] b);
        longint sa, sb, q, r;
        logic [63:0] p;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        if (!o[1]) begin
            if (o[0]) p = {32'b0, a} * {32'b0, b};
            else      p = sa * sb;
            return p;
        end
        if (b == 32'd0) return {a, 32'hFFFFFFFF};
        if (o[0]) return {a % b, a / b};
        q = sa / sb;
        r = sa % sb;
        return {r[31:0], q[31:0]};
    endfunction

    function automatic string tag_of(input logic [1:0] o, input logic [31:0] b);
        if (!o[1]) return o[0] ? "R1" : "R2";
        if (b == 32'd0) return "R5";
        return o[0] ? "R3" : "R4";
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic start_op(input logic [1:0] o, input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        start = 1'b1; op = o; src_a = a; src_b = b;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic read_reg(input logic sel, output logic [31:0] d, output logic v);
        @(negedge clk);
        rd_req = 1'b1; rd_sel = sel;
        #1;
        d = rd_data; v = rd_valid;
        rd_req = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic        v;
        logic [63:0] exp;
        int          n;

        rst = 1'b1; start = 1'b0; op = 2'b00; src_a = '0; src_b = '0;
        wr_hi = 1'b0; wr_lo = 1'b0; wr_data = '0; rd_req = 1'b0; rd_sel = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R11: reset state
        check("R11 busy", {63'b0, busy}, 64'd0);
        read_reg(1'b0, d, v);
        check("R11 lo", {32'b0, d}, 64'd0);
        read_reg(1'b1, d, v);
        check("R11 hi", {32'b0, d}, 64'd0);

        // Table-driven operations (R1..R5), with busy length (R6)
        for (int i = 0; i < NV; i++) begin
            logic [31:0] h;
            logic [31:0] l;
            start_op(VEC[i][65:64], VEC[i][63:32], VEC[i][31:0]);
            wait_idle(n);
            check("R6 busy cycles", 64'(n), 64'd32);
            exp = model(VEC[i][65:64], VEC[i][63:32], VEC[i][31:0]);
            read_reg(1'b1, h, v);
            read_reg(1'b0, l, v);
            check(tag_of(VEC[i][65:64], VEC[i][31:0]), {h, l}, exp);
        end

        // R8: idle moves, one register at a time
        @(negedge clk); wr_hi = 1'b1; wr_data = 32'hAAAA5555;
        @(negedge clk); wr_hi = 1'b0;
        read_reg(1'b0, d, v);
        check("R8 lo untouched", {32'b0, d}, {32'b0, 32'd1234 % 32'd1 == 0 ? 32'hFFFFFFFF : 32'hFFFFFFFF});
        @(negedge clk); wr_lo = 1'b1; wr_data = 32'h0BADF00D;
        @(negedge clk); wr_lo = 1'b0;
        read_reg(1'b1, d, v);
        check("R8 hi", {32'b0, d}, {32'b0, 32'hAAAA5555});
        read_reg(1'b0, d, v);
        check("R8 lo", {32'b0, d}, {32'b0, 32'h0BADF00D});
        check("R10 valid idle", {63'b0, v}, 64'd1);

        // R9 and R10: move and read attempts during an operation
        start_op(2'b01, 32'd2, 32'd3);
        wr_hi = 1'b1; wr_lo = 1'b1; wr_data = 32'hDEADBEEF;
        rd_req = 1'b1; rd_sel = 1'b1;
        #1;
        check("R10 valid while busy", {63'b0, rd_valid}, 64'd0);
        @(negedge clk);
        wr_hi = 1'b0; wr_lo = 1'b0; rd_req = 1'b0;
        wait_idle(n);
        check("R6 busy with moves", 64'(n + 1), 64'd32);
        read_reg(1'b1, d, v);
        check("R9 hi", {32'b0, d}, 64'd0);
        check("R10 valid after", {63'b0, v}, 64'd1);
        read_reg(1'b0, d, v);
        check("R9 lo", {32'b0, d}, 64'd6);

        // R7: second start while busy
        start_op(2'b01, 32'd11, 32'd13);
        start = 1'b1; op = 2'b11; src_a = 32'd100; src_b = 32'd7;
        @(negedge clk);
        start = 1'b0;
        wait_idle(n);
        check("R7 busy not extended", 64'(n + 1), 64'd32);
        read_reg(1'b0, d, v);
        check("R7 lo", {32'b0, d}, 64'd143);
        read_reg(1'b1, d, v);
        check("R7 hi", {32'b0, d}, 64'd0);
        repeat (3) @(negedge clk);
        check("R7 idle after", {63'b0, busy}, 64'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule